// File: doc/BRIEF.md
# External register access port

This block sits between a register block's CPU-side decoder and a register whose storage and behaviour are implemented elsewhere by the designer. The decoder presents an access: a valid flag, a write flag, the index of the bus-width slice (sub-word) within the register, the write data and per-bit write enables. The port turns that access into a strobe toward the external logic, along with the direction, data and enables. It then waits for the external side to report completion with a read or a write acknowledge. When that acknowledge arrives, the port hands the completion, and on reads the data, back to the decoder.

The register may be wider than the bus. In that case the strobe has one bit per sub-word, and only the addressed slice is strobed. A register built without readable fields never sees a read strobe, and one without writable fields never sees a write strobe. Such an access is completed locally instead. The external latency is unknown, so the port keeps at most one access in flight. It holds the decoder off until that access is acknowledged. By default the outgoing request is a combinational image of the accepted access. A parameter instead places it behind one register stage.

Top module: `ext_reg_port`

## Requirements
- R1: `ext_req` has NSUB = REG_W/BUS_W bits, and bit k refers to sub-word k. At most one bit is ever high, and it is bit `cpu_sub` of the access being launched. With no launch the strobe is all zero.
- R2: Whenever `ext_req` is non-zero, `ext_req_wr` (1 = write, 0 = read), `ext_wdata` and `ext_biten` equal the `cpu_wr`, `cpu_wdata` and `cpu_biten` of the launched access, at the full bus width. The external register changes only the bits enabled in `ext_biten`.
- R3: With READABLE = 0, a read never raises `ext_req`. It completes with `cpu_done` = 1 and `cpu_rdata` = 0 in its launch cycle.
- R4: With WRITABLE = 0, a write never raises `ext_req`. It completes with `cpu_done` = 1 in its launch cycle.
- R5: Once a strobe has gone out without an acknowledge in the same cycle, `cpu_ready` stays low and no further strobe is issued until the matching acknowledge is seen. A request that is held valid meanwhile is stalled.
- R6: An acknowledge in the same cycle as the strobe completes the access in that cycle, and the port remains ready.
- R7: `cpu_done` pulses in exactly the cycle the matching acknowledge (`ext_rd_ack` for a read, `ext_wr_ack` for a write) is seen. On a read, `cpu_rdata` equals `ext_rd_data` in that cycle. It is 0 otherwise.
- R8: An acknowledge with nothing in flight, or of the wrong direction for the access in flight, produces no `cpu_done` and does not end the access.
- R9: With RETIME = 1, the strobe and its qualifiers appear one cycle after the access is accepted. They never appear in the acceptance cycle, and `cpu_ready` is low in the cycle after acceptance.
- R10: While `rst_n` is low, `ext_req` is zero, `cpu_done` is low and `cpu_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Access request from the decoder |
| cpu_ready | output | 1 | Access accepted when high together with cpu_valid |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_sub | input | IDX_W | Sub-word index inside the register |
| cpu_wdata | input | BUS_W | Write data |
| cpu_biten | input | BUS_W | Per-bit write enables, active high |
| cpu_done | output | 1 | Completion pulse |
| cpu_rdata | output | BUS_W | Read data, valid with cpu_done on reads |
| ext_req | output | NSUB | Per-sub-word transfer strobe |
| ext_req_wr | output | 1 | Direction of the strobed transfer |
| ext_wdata | output | BUS_W | Write data toward the external register |
| ext_biten | output | BUS_W | Write bit enables toward the external register |
| ext_rd_ack | input | 1 | Read completion strobe |
| ext_rd_data | input | BUS_W | Read data, qualified by ext_rd_ack |
| ext_wr_ack | input | 1 | Write completion strobe |

## Verification
The hardest situation to reach is a second request waiting on a held `cpu_valid` while an acknowledge of the wrong direction arrives for the access in flight. The port must neither finish early nor let the waiting request through. The bench's stub register answers after a latency it selects per access. The bench holds valid with a new access right after the first is accepted, and it injects stray acknowledges both while idle and during a slow read. A behavioural model of the port checks the strobe, ready, done and data on every clock. Separate instances cover the retimed stage and the two suppression cases.

// File: rtl/ext_reg_pkg.sv
// Package: shared types of the external register access port.
// Assumes nothing beyond synthesizable SystemVerilog.
package ext_reg_pkg;

    // What happens to an access in the cycle it reaches the external side
    typedef enum logic [1:0] {
        LAUNCH_NONE  = 2'd0,   // nothing launched
        LAUNCH_ISSUE = 2'd1,   // strobe goes to the external register
        LAUNCH_LOCAL = 2'd2    // suppressed, completed inside the port
    } launch_kind_e;

endpackage

// File: rtl/ext_req_gate.sv
// Module: ext_req_gate
// Decides whether a launched access is strobed out or completed locally,
// and builds the one-hot per-sub-word strobe.
// Assumes: l_v marks the single cycle an access is launched.
module ext_req_gate
    import ext_reg_pkg::*;
#(
    parameter int NSUB     = 2,
    parameter int IDX_W    = 1,
    parameter bit READABLE = 1'b1,
    parameter bit WRITABLE = 1'b1
) (
    input  logic             l_v,
    input  logic             l_wr,
    input  logic [IDX_W-1:0] l_sub,
    output launch_kind_e     kind,
    output logic [NSUB-1:0]  strobe
);

    logic allowed;
    logic in_range;

    // Direction is permitted by the register's field access rights
    always_comb allowed = l_wr ? WRITABLE : READABLE;

    // Sub-word index names a slice that exists
    always_comb in_range = (int'(l_sub) < NSUB);

    // Classify the launch
    always_comb begin
        if (!l_v)
            kind = LAUNCH_NONE;
        else if (allowed && in_range)
            kind = LAUNCH_ISSUE;
        else
            kind = LAUNCH_LOCAL;
    end

    // One strobe bit per sub-word
    for (genvar k = 0; k < NSUB; k++) begin : g_strobe
        always_comb strobe[k] = (kind == LAUNCH_ISSUE) && (l_sub == IDX_W'(k));
    end

endmodule

// File: rtl/ext_txn_tracker.sv
// Module: ext_txn_tracker
// Tracks the single outstanding external transfer, matches acknowledges
// by direction and forms the CPU-side completion.
// Assumes: kind is LAUNCH_ISSUE only while nothing is pending.
module ext_txn_tracker
    import ext_reg_pkg::*;
#(
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  launch_kind_e     kind,
    input  logic             l_wr,
    input  logic             rd_ack,
    input  logic             wr_ack,
    input  logic [BUS_W-1:0] rd_data,
    output logic             pend,
    output logic             done,
    output logic [BUS_W-1:0] rdata
);

    logic issue;
    logic live;
    logic cur_wr;
    logic hit;
    logic pend_wr;

    // A transfer is live in its issue cycle and while pending
    always_comb begin
        issue  = (kind == LAUNCH_ISSUE);
        live   = issue || pend;
        cur_wr = issue ? l_wr : pend_wr;
    end

    // Only the acknowledge of the live direction completes the transfer
    always_comb hit = live && (cur_wr ? wr_ack : rd_ack);

    // Completion and read data toward the CPU side
    always_comb begin
        done  = hit || (kind == LAUNCH_LOCAL);
        rdata = (hit && !cur_wr) ? rd_data : '0;
    end

    // Outstanding flag and its direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            pend_wr <= 1'b0;
        end else if (hit) begin
            pend    <= 1'b0;
        end else if (issue) begin
            pend    <= 1'b1;
            pend_wr <= l_wr;
        end
    end

endmodule

// File: rtl/ext_reg_port.sv
// Module: ext_reg_port (top)
// Bridges a CPU-side register access to an externally implemented register:
// per-sub-word strobe, direction, data and bit enables out; read/write
// acknowledges back. One transfer in flight at most. RETIME selects a
// registered output stage instead of a combinational one.
// Assumes: REG_W is a multiple of BUS_W; acknowledges are single-cycle.
module ext_reg_port
    import ext_reg_pkg::*;
#(
    parameter int BUS_W    = 32,
    parameter int REG_W    = 64,
    parameter bit READABLE = 1'b1,
    parameter bit WRITABLE = 1'b1,
    parameter bit RETIME   = 1'b0,
    localparam int NSUB    = REG_W / BUS_W,
    localparam int IDX_W   = (NSUB > 1) ? $clog2(NSUB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    output logic             cpu_ready,
    input  logic             cpu_wr,
    input  logic [IDX_W-1:0] cpu_sub,
    input  logic [BUS_W-1:0] cpu_wdata,
    input  logic [BUS_W-1:0] cpu_biten,
    output logic             cpu_done,
    output logic [BUS_W-1:0] cpu_rdata,
    output logic [NSUB-1:0]  ext_req,
    output logic             ext_req_wr,
    output logic [BUS_W-1:0] ext_wdata,
    output logic [BUS_W-1:0] ext_biten,
    input  logic             ext_rd_ack,
    input  logic [BUS_W-1:0] ext_rd_data,
    input  logic             ext_wr_ack
);

    logic             acc;
    logic             pend;
    logic             stage_busy;
    logic             l_v;
    logic             l_wr;
    logic [IDX_W-1:0] l_sub;
    logic [BUS_W-1:0] l_wd;
    logic [BUS_W-1:0] l_be;
    launch_kind_e     kind;

    // Accept only when nothing is in flight or waiting in the stage
    always_comb begin
        cpu_ready = !pend && !stage_busy;
        acc       = cpu_valid && cpu_ready;
    end

    if (RETIME) begin : g_retime
        logic             s_v;
        logic             s_wr;
        logic [IDX_W-1:0] s_sub;
        logic [BUS_W-1:0] s_wd;
        logic [BUS_W-1:0] s_be;

        // Register the accepted access; it launches in the following cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s_v   <= 1'b0;
                s_wr  <= 1'b0;
                s_sub <= '0;
                s_wd  <= '0;
                s_be  <= '0;
            end else begin
                s_v <= acc;
                if (acc) begin
                    s_wr  <= cpu_wr;
                    s_sub <= cpu_sub;
                    s_wd  <= cpu_wdata;
                    s_be  <= cpu_biten;
                end
            end
        end

        // Launch from the stage
        always_comb begin
            l_v        = s_v;
            l_wr       = s_wr;
            l_sub      = s_sub;
            l_wd       = s_wd;
            l_be       = s_be;
            stage_busy = s_v;
        end
    end else begin : g_comb
        // Launch straight from the accepted access
        always_comb begin
            l_v        = acc;
            l_wr       = cpu_wr;
            l_sub      = cpu_sub;
            l_wd       = cpu_wdata;
            l_be       = cpu_biten;
            stage_busy = 1'b0;
        end
    end

    ext_req_gate #(
        .NSUB     (NSUB),
        .IDX_W    (IDX_W),
        .READABLE (READABLE),
        .WRITABLE (WRITABLE)
    ) gate_i (
        .l_v    (l_v),
        .l_wr   (l_wr),
        .l_sub  (l_sub),
        .kind   (kind),
        .strobe (ext_req)
    );

    ext_txn_tracker #(
        .BUS_W (BUS_W)
    ) trk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .kind    (kind),
        .l_wr    (l_wr),
        .rd_ack  (ext_rd_ack),
        .wr_ack  (ext_wr_ack),
        .rd_data (ext_rd_data),
        .pend    (pend),
        .done    (cpu_done),
        .rdata   (cpu_rdata)
    );

    // Request qualifiers follow the launched access
    always_comb begin
        ext_req_wr = l_wr;
        ext_wdata  = l_wd;
        ext_biten  = l_be;
    end

endmodule

// File: rtl/ext_reg_port_chk.sv
// Module: ext_reg_port_chk
// Port-level properties of ext_reg_port, attached with bind.
// Assumes: the bound instance's parameters are passed through unchanged.
module ext_reg_port_chk #(
    parameter int NSUB     = 2,
    parameter bit READABLE = 1'b1,
    parameter bit WRITABLE = 1'b1,
    parameter bit RETIME   = 1'b0
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cpu_valid,
    input logic            cpu_ready,
    input logic            cpu_done,
    input logic [NSUB-1:0] ext_req,
    input logic            ext_req_wr
);

    // R1
    req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ext_req));

    // R5
    issue_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req != '0 && !cpu_done) |=> !cpu_ready);

    // R5
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req != '0 && !cpu_done) |=> (ext_req == '0));

    if (!READABLE) begin : g_no_rd
        // R3
        no_rd_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_req != '0) |-> ext_req_wr);
    end

    if (!WRITABLE) begin : g_no_wr
        // R4
        no_wr_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ext_req != '0) |-> !ext_req_wr);
    end

    if (RETIME) begin : g_rt
        // R9
        rt_no_same_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_valid && cpu_ready) |-> (ext_req == '0));

        // R9
        rt_ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cpu_valid && cpu_ready) |=> !cpu_ready);
    end

endmodule

bind ext_reg_port ext_reg_port_chk #(
    .NSUB     (NSUB),
    .READABLE (READABLE),
    .WRITABLE (WRITABLE),
    .RETIME   (RETIME)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_valid  (cpu_valid),
    .cpu_ready  (cpu_ready),
    .cpu_done   (cpu_done),
    .ext_req    (ext_req),
    .ext_req_wr (ext_req_wr)
);

// File: tb/ext_reg_port_tb_top.sv
`timescale 1ns/1ps
// Bench: dut_i (4 sub-words, combinational) against a behavioural model every
// clock, with a stub register of selectable latency; plus directed instances
// for the retimed stage and the read/write suppression cases.
module ext_reg_port_tb_top;

    localparam int BW = 32;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- main instance ----------------
    logic          cpu_valid = 0, cpu_wr = 0;
    logic [1:0]    cpu_sub = 0;
    logic [BW-1:0] cpu_wdata = 0, cpu_biten = 0;
    logic          cpu_ready, cpu_done;
    logic [BW-1:0] cpu_rdata;
    logic [NS-1:0] ext_req;
    logic          ext_req_wr, ext_rd_ack, ext_wr_ack;
    logic [BW-1:0] ext_wdata, ext_biten, ext_rd_data;

    ext_reg_port #(.BUS_W(BW), .REG_W(BW*NS)) dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
        .cpu_wr(cpu_wr), .cpu_sub(cpu_sub), .cpu_wdata(cpu_wdata), .cpu_biten(cpu_biten),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .ext_req(ext_req),
        .ext_req_wr(ext_req_wr), .ext_wdata(ext_wdata), .ext_biten(ext_biten),
        .ext_rd_ack(ext_rd_ack), .ext_rd_data(ext_rd_data), .ext_wr_ack(ext_wr_ack));

    // stub external register
    logic [BW-1:0] mem [NS];
    int            lat = 0;
    logic          stray_rd = 0, stray_wr = 0;
    logic          st_pend;
    int            st_cnt;
    logic          st_wr;
    int            st_sub;
    logic [BW-1:0] st_wd, st_be;
    int            req_idx;

    always_comb begin
        req_idx = 0;
        for (int k = 0; k < NS; k++) if (ext_req[k]) req_idx = k;
    end

    always_comb begin
        ext_rd_ack  = stray_rd || (lat == 0 && ext_req != 0 && !ext_req_wr)
                      || (st_pend && st_cnt == 0 && !st_wr);
        ext_wr_ack  = stray_wr || (lat == 0 && ext_req != 0 && ext_req_wr)
                      || (st_pend && st_cnt == 0 && st_wr);
        ext_rd_data = st_pend ? mem[st_sub] : mem[req_idx];
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            st_pend <= 0; st_cnt <= 0; st_wr <= 0; st_sub <= 0;
            for (int k = 0; k < NS; k++) mem[k] <= 32'h1000_0000 + k;
        end else if (ext_req != 0) begin
            if (lat == 0) begin
                if (ext_req_wr)
                    mem[req_idx] <= (mem[req_idx] & ~ext_biten) | (ext_wdata & ext_biten);
            end else begin
                st_pend <= 1; st_cnt <= lat - 1; st_wr <= ext_req_wr;
                st_sub <= req_idx; st_wd <= ext_wdata; st_be <= ext_biten;
            end
        end else if (st_pend) begin
            if (st_cnt == 0) begin
                if (st_wr) mem[st_sub] <= (mem[st_sub] & ~st_be) | (st_wd & st_be);
                st_pend <= 0;
            end else st_cnt <= st_cnt - 1;
        end
    end

    // behavioural reference model, compared every clock
    bit   m_out = 0, m_wr = 0;
    int   m_sub = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            m_out = 0;
        end else begin
            bit   launch, cw, hit;
            int   sb;
            logic [NS-1:0] e_req;
            string dtag;
            launch = cpu_valid && !m_out;
            e_req  = launch ? (NS'(1) << cpu_sub) : '0;
            cw     = launch ? cpu_wr : m_wr;
            sb     = launch ? int'(cpu_sub) : m_sub;
            hit    = (launch || m_out) && (cw ? ext_wr_ack : ext_rd_ack);
            dtag   = (stray_rd || stray_wr) ? "R8 stray ack" :
                     (launch && hit) ? "R6 same-cycle ack" : "R7 completion";
            check("R5 ready", cpu_ready, !m_out);
            check("R1 strobe", ext_req, e_req);
            if (e_req != 0) begin
                check("R2 direction", ext_req_wr, cpu_wr);
                check("R2 wdata", ext_wdata, cpu_wdata);
                check("R2 biten", ext_biten, cpu_biten);
            end
            check(dtag, cpu_done, hit);
            check("R7 rdata", cpu_rdata, (hit && !cw) ? mem[sb] : '0);
            if (hit) m_out = 0;
            else if (launch) begin m_out = 1; m_wr = cpu_wr; m_sub = int'(cpu_sub); end
        end
    end

    task automatic send(input logic wr, input int sub, input logic [BW-1:0] wd, input logic [BW-1:0] be);
        cpu_valid = 1; cpu_wr = wr; cpu_sub = 2'(sub); cpu_wdata = wd; cpu_biten = be;
        @(negedge clk);
        while (!cpu_ready) @(negedge clk);
        @(posedge clk); #1;
    endtask

    task automatic finish_xfer();
        cpu_valid = 0;
        repeat (lat + 3) @(posedge clk);
        #1;
    endtask

    // ---------------- retimed instance ----------------
    logic          rt_valid = 0, rt_wr = 0;
    logic [1:0]    rt_sub = 0;
    logic [BW-1:0] rt_wd = 0, rt_be = 0;
    logic          rt_ready, rt_done, rt_req_wr;
    logic [BW-1:0] rt_rdata, rt_xwd, rt_xbe;
    logic [NS-1:0] rt_req;

    ext_reg_port #(.BUS_W(BW), .REG_W(BW*NS), .RETIME(1'b1)) dut_rt (
        .clk(clk), .rst_n(rst_n), .cpu_valid(rt_valid), .cpu_ready(rt_ready),
        .cpu_wr(rt_wr), .cpu_sub(rt_sub), .cpu_wdata(rt_wd), .cpu_biten(rt_be),
        .cpu_done(rt_done), .cpu_rdata(rt_rdata), .ext_req(rt_req),
        .ext_req_wr(rt_req_wr), .ext_wdata(rt_xwd), .ext_biten(rt_xbe),
        .ext_rd_ack(rt_req != 0 && !rt_req_wr), .ext_rd_data(32'hA5A5_0003),
        .ext_wr_ack(rt_req != 0 && rt_req_wr));

    // ---------------- suppression instances ----------------
    logic          s_valid = 0, s_wr = 0;
    logic          s_sub = 0;
    logic [BW-1:0] s_wd = 0, s_be = 0;
    logic          ro_ready, ro_done, ro_req_wr, wo_ready, wo_done, wo_req_wr;
    logic [BW-1:0] ro_rdata, ro_xwd, ro_xbe, wo_rdata, wo_xwd, wo_xbe;
    logic [1:0]    ro_req, wo_req;

    ext_reg_port #(.BUS_W(BW), .REG_W(BW*2), .WRITABLE(1'b0)) dut_ro (
        .clk(clk), .rst_n(rst_n), .cpu_valid(s_valid), .cpu_ready(ro_ready),
        .cpu_wr(s_wr), .cpu_sub(s_sub), .cpu_wdata(s_wd), .cpu_biten(s_be),
        .cpu_done(ro_done), .cpu_rdata(ro_rdata), .ext_req(ro_req),
        .ext_req_wr(ro_req_wr), .ext_wdata(ro_xwd), .ext_biten(ro_xbe),
        .ext_rd_ack(ro_req != 0 && !ro_req_wr), .ext_rd_data(32'h1234_5678),
        .ext_wr_ack(ro_req != 0 && ro_req_wr));

    ext_reg_port #(.BUS_W(BW), .REG_W(BW*2), .READABLE(1'b0)) dut_wo (
        .clk(clk), .rst_n(rst_n), .cpu_valid(s_valid), .cpu_ready(wo_ready),
        .cpu_wr(s_wr), .cpu_sub(s_sub), .cpu_wdata(s_wd), .cpu_biten(s_be),
        .cpu_done(wo_done), .cpu_rdata(wo_rdata), .ext_req(wo_req),
        .ext_req_wr(wo_req_wr), .ext_wdata(wo_xwd), .ext_biten(wo_xbe),
        .ext_rd_ack(wo_req != 0 && !wo_req_wr), .ext_rd_data(32'h1234_5678),
        .ext_wr_ack(wo_req != 0 && wo_req_wr));

    // ---------------- summary and watchdog ----------------
    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R10 reset ready", cpu_ready, 1'b1);
        check("R10 reset strobe", ext_req, '0);
        check("R10 reset done", cpu_done, 1'b0);
        check("R10 reset rt strobe", rt_req, '0);
        @(posedge clk); #1 rst_n = 1;
        @(posedge clk); #1;

        // same-cycle acknowledge (R6)
        lat = 0;
        send(1, 0, 32'hCAFE_F00D, 32'hFFFF_FFFF); finish_xfer();
        send(0, 0, 0, 0); finish_xfer();

        // slow acknowledge with partial bit enables (R2, R7)
        lat = 3;
        send(1, 2, 32'hABCD_1234, 32'h0000_FFFF); finish_xfer();
        send(0, 2, 0, 0); finish_xfer();

        // held request stalls behind an outstanding one (R5)
        lat = 2;
        send(1, 1, 32'h5555_AAAA, 32'hFF00_FF00);
        send(0, 1, 0, 0);
        finish_xfer();

        // stray acknowledges while idle (R8)
        stray_rd = 1; @(posedge clk); #1 stray_rd = 0;
        stray_wr = 1; @(posedge clk); #1 stray_wr = 0;

        // wrong-direction ack during a slow read (R8)
        lat = 4;
        send(0, 3, 0, 0);
        cpu_valid = 0;
        stray_wr = 1; @(posedge clk); #1 stray_wr = 0;
        repeat (5) @(posedge clk); #1;

        // every sub-word, both latencies (R1, R7)
        for (int s = 0; s < NS; s++) begin
            lat = s % 2;
            send(1, s, 32'h0F0F_0000 + s, 32'hFFFF_FFFF); finish_xfer();
            send(0, s, 0, 0); finish_xfer();
        end

        // retimed stage: read (R9, R6, R7)
        rt_valid = 1; rt_wr = 0; rt_sub = 3;
        @(negedge clk);
        check("R9 rt no strobe at accept", rt_req, '0);
        check("R9 rt ready at accept", rt_ready, 1'b1);
        @(posedge clk); #1 rt_valid = 0;
        @(negedge clk);
        check("R9 rt strobe next cycle", rt_req, 4'b1000);
        check("R5 rt ready low", rt_ready, 1'b0);
        check("R6 rt done", rt_done, 1'b1);
        check("R7 rt rdata", rt_rdata, 32'hA5A5_0003);
        @(negedge clk);
        check("R9 rt ready back", rt_ready, 1'b1);
        check("R7 rt done single", rt_done, 1'b0);
        // retimed stage: write (R2, R9)
        @(posedge clk); #1 rt_valid = 1; rt_wr = 1; rt_sub = 1; rt_wd = 32'h7777_1111; rt_be = 32'h00FF_00FF;
        @(posedge clk); #1 rt_valid = 0; rt_wd = 0; rt_be = 0;
        @(negedge clk);
        check("R9 rt write strobe", rt_req, 4'b0010);
        check("R2 rt direction", rt_req_wr, 1'b1);
        check("R2 rt wdata", rt_xwd, 32'h7777_1111);
        check("R2 rt biten", rt_xbe, 32'h00FF_00FF);
        check("R7 rt write done", rt_done, 1'b1);

        // suppression: write to read-only, read of write-only (R3, R4)
        @(posedge clk); #1 s_valid = 1; s_wr = 1; s_sub = 1; s_wd = 32'h9999_9999; s_be = '1;
        @(negedge clk);
        check("R4 ro no write strobe", ro_req, 2'b00);
        check("R4 ro local done", ro_done, 1'b1);
        check("R2 wo write strobe", wo_req, 2'b10);
        check("R7 wo write done", wo_done, 1'b1);
        @(posedge clk); #1 s_wr = 0;
        @(negedge clk);
        check("R3 wo no read strobe", wo_req, 2'b00);
        check("R3 wo local done", wo_done, 1'b1);
        check("R3 wo rdata zero", wo_rdata, '0);
        check("R1 ro read strobe", ro_req, 2'b10);
        check("R7 ro rdata", ro_rdata, 32'h1234_5678);
        @(posedge clk); #1 s_valid = 0;
        @(negedge clk);
        check("R4 ro idle done", ro_done, 1'b0);

        repeat (2) @(posedge clk);
        finished = 1'b1;
        summary();
        $finish;
    end

endmodule